// File: doc/BRIEF.md
# Opcode Byte Length Classifier

This block inspects the leading byte of an instruction from a byte-oriented instruction set whose instructions span one to seven bytes. It reports how many bytes the whole instruction occupies, so that a fetch stage can find where the next instruction starts without decoding any operands.

The classification uses a set of mask-and-compare patterns, grouped by length. The groups are tried from the shortest length to the longest, and the first group that matches decides the result. Some byte ranges have no fixed length. In the upper-nibble range 0x8 to 0xB, the length depends on whether the two 2-bit sub-fields of the low nibble are equal.

In the default build the result is registered. A byte presented with its strobe high on one clock edge produces a length and a valid flag that can be read during the following cycle.

Top module: `vld_len_decoder`

## Requirements
- R1: A synchronous active-high reset clears `len_valid` to 0 and sets `len_bytes` to 1.
- R2: `len_valid` in each cycle equals the value `in_valid` had at the previous rising clock edge.
- R3: `len_bytes` is the plain binary byte count, from 1 to 7; 0 is never produced.
- R4: The following bytes are 1 byte long: low-nibble patterns 0x0, 0x4, 0x8 and 0xC under upper nibble 0x0 (b & 0xF3 = 0x00); b & 0xF3 = 0x40 or 0x41; upper nibble 0x1, 0x6, 0x7 or 0xE; b & 0xFC = 0x3C, 0x50, 0x54, 0xD0, 0xD4 or 0xD8; and the single values 0xCB and 0xFF.
- R5: For an upper nibble of 0x8 to 0xB, the byte is 1 byte long when bits [3:2] differ from bits [1:0], and 2 bytes long when they are equal.
- R6: The following bytes are 2 bytes long: b & 0xFC = 0x20, 0x28, 0x58 or 0x5C; b & 0xF3 = 0x42 or 0x43; any byte with upper nibble 0xC other than 0xCB, 0xCC and 0xCD; and 0xF0 to 0xF6.
- R7: The following bytes are 3 bytes long: 0xCC, 0xDE, 0xDF, 0xF8 and 0xF9; b & 0xF3 = 0x01, 0x02 or 0x03; b & 0xFC = 0x24, 0x2C, 0x30, 0x34 or 0x38.
- R8: 0xFA and 0xFB give 4; 0xCD and 0xDC give 5; 0xFC and 0xFD give 6.
- R9: A byte matched by no shorter class gives 7 (0xDD, 0xF7 and 0xFE).
- R10: When a byte matches patterns of several lengths, the shortest length wins. For example, 0xCB gives 1 even though it lies in upper nibble 0xC.
- R11: While `in_valid` is low at a clock edge, `len_bytes` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Opcode byte strobe |
| in_byte | input | 8 | First byte of the instruction |
| len_valid | output | 1 | Result valid, one cycle after the strobe |
| len_bytes | output | 3 | Instruction length in bytes (1 to 7) |

## Verification
The bench sweeps all 256 byte values and compares each result with a reference written as a per-nibble case table, so every overlap between patterns is covered.

The corner cases it targets are these:
- Diagonal bytes such as 0x80, 0x95, 0xAA and 0xBF. A design that ignored the sub-field comparison would report 1 for them instead of 2.
- The exclusions 0xCB, 0xCC and 0xCD in the 0xC row. A design with the wrong class priority would report 2 for them.
- The three bytes that fall through to 7. A design with a missing default would give 0 or a short length for them.

Idle cycles with a changing byte check that the held length does not move.

// File: rtl/vld_pkg.sv
package vld_pkg;
   localparam int OPC_W   = 8;
   localparam int LEN_W   = 3;
   localparam int CLASS_N = 7;

   typedef logic [OPC_W-1:0]   opc_t;
   typedef logic [LEN_W-1:0]   len_t;
   typedef logic [CLASS_N-1:0] cls_vec_t;
endpackage

// File: rtl/vld_pattern_bank.sv
// Generic bank of mask/compare terms; hit when any entry matches.
module vld_pattern_bank #(
   parameter int               W       = 8,
   parameter int               N       = 1,
   parameter logic [N*W-1:0]   MASKS   = '0,
   parameter logic [N*W-1:0]   VALUES  = '0
) (
   input  logic [W-1:0] byte_i,
   output logic         hit_o
);
   localparam int N_CHK = N;

   if (N_CHK < 1) begin : g_bad_n
      $error("vld_pattern_bank: N must be at least 1");
   end

   logic [N-1:0] term;

   for (genvar i = 0; i < N; i++) begin : g_term
      localparam logic [W-1:0] M = MASKS[i*W +: W];
      localparam logic [W-1:0] V = VALUES[i*W +: W];
      if ((V & ~M) != '0) begin : g_bad_pair
         $error("vld_pattern_bank: compare value has bits outside its mask");
      end
      assign term[i] = ((byte_i & M) == V);
   end

   assign hit_o = |term;
endmodule

// File: rtl/vld_class_match.sv
// Produces one raw hit per length class; priority is resolved downstream.
module vld_class_match
   import vld_pkg::*;
#(
   parameter int W = OPC_W,
   parameter int N_CLASS = CLASS_N
) (
   input  logic [W-1:0]       byte_i,
   output logic [N_CLASS-1:0] hit_o
);
   if (W != 8) begin : g_bad_w
      $error("vld_class_match: pattern tables are written for 8-bit opcodes");
   end
   if (N_CLASS != 7) begin : g_bad_cls
      $error("vld_class_match: exactly seven length classes are defined");
   end

   // ---- single-byte patterns ----
   logic one_tab;
   vld_pattern_bank #(
      .W(W), .N(15),
      .MASKS ({8'hFF,8'hFF, 8'hFC,8'hFC,8'hFC,8'hFC,8'hFC,8'hFC,
               8'hF0,8'hF0,8'hF0,8'hF0, 8'hF3,8'hF3,8'hF3}),
      .VALUES({8'hFF,8'hCB, 8'hD8,8'hD4,8'hD0,8'h54,8'h50,8'h3C,
               8'hE0,8'h70,8'h60,8'h10, 8'h41,8'h40,8'h00})
   ) u_one (.byte_i(byte_i), .hit_o(one_tab));

   // ---- upper-nibble 0x8..0xB group with sub-field comparison ----
   logic grp_hi;
   logic diag_eq;
   vld_pattern_bank #(
      .W(W), .N(1), .MASKS(8'hC0), .VALUES(8'h80)
   ) u_grp (.byte_i(byte_i), .hit_o(grp_hi));
   assign diag_eq = (byte_i[3:2] == byte_i[1:0]);

   // ---- two-byte patterns ----
   logic two_tab;
   vld_pattern_bank #(
      .W(W), .N(9),
      .MASKS ({8'hFF,8'hFE,8'hFC, 8'hF3,8'hF3, 8'hFC,8'hFC,8'hFC,8'hFC}),
      .VALUES({8'hF6,8'hF4,8'hF0, 8'h43,8'h42, 8'h5C,8'h58,8'h28,8'h20})
   ) u_two (.byte_i(byte_i), .hit_o(two_tab));

   logic row_c;
   logic row_c_excl;
   vld_pattern_bank #(
      .W(W), .N(1), .MASKS(8'hF0), .VALUES(8'hC0)
   ) u_rowc (.byte_i(byte_i), .hit_o(row_c));
   vld_pattern_bank #(
      .W(W), .N(3),
      .MASKS ({8'hFF,8'hFF,8'hFF}),
      .VALUES({8'hCD,8'hCC,8'hCB})
   ) u_rowc_x (.byte_i(byte_i), .hit_o(row_c_excl));

   // ---- three-byte patterns ----
   logic three_tab;
   vld_pattern_bank #(
      .W(W), .N(13),
      .MASKS ({8'hFC,8'hFC,8'hFC,8'hFC,8'hFC, 8'hF3,8'hF3,8'hF3,
               8'hFF,8'hFF,8'hFF,8'hFF,8'hFF}),
      .VALUES({8'h38,8'h34,8'h30,8'h2C,8'h24, 8'h03,8'h02,8'h01,
               8'hDF,8'hDE,8'hCC,8'hF9,8'hF8})
   ) u_three (.byte_i(byte_i), .hit_o(three_tab));

   // ---- long forms ----
   logic four_tab;
   logic five_tab;
   logic six_tab;
   vld_pattern_bank #(
      .W(W), .N(1), .MASKS(8'hFE), .VALUES(8'hFA)
   ) u_four (.byte_i(byte_i), .hit_o(four_tab));
   vld_pattern_bank #(
      .W(W), .N(2), .MASKS({8'hFF,8'hFF}), .VALUES({8'hDC,8'hCD})
   ) u_five (.byte_i(byte_i), .hit_o(five_tab));
   vld_pattern_bank #(
      .W(W), .N(1), .MASKS(8'hFE), .VALUES(8'hFC)
   ) u_six (.byte_i(byte_i), .hit_o(six_tab));

   assign hit_o[0] = one_tab | (grp_hi & ~diag_eq);
   assign hit_o[1] = two_tab | grp_hi | (row_c & ~row_c_excl);
   assign hit_o[2] = three_tab;
   assign hit_o[3] = four_tab;
   assign hit_o[4] = five_tab;
   assign hit_o[5] = six_tab;
   assign hit_o[6] = 1'b1;
endmodule

// File: rtl/vld_prio_len.sv
// Lowest-index hit wins; output is index + 1.
module vld_prio_len #(
   parameter int N_CLASS = 7,
   parameter int LEN_W   = 3
) (
   input  logic [N_CLASS-1:0] hit_i,
   output logic [LEN_W-1:0]   len_o
);
   if ((1 << LEN_W) <= N_CLASS) begin : g_bad_len
      $error("vld_prio_len: LEN_W too narrow for N_CLASS");
   end

   logic [N_CLASS-1:0] blocked;
   logic [N_CLASS-1:0] win;

   assign blocked[0] = 1'b0;
   for (genvar k = 1; k < N_CLASS; k++) begin : g_chain
      assign blocked[k] = blocked[k-1] | hit_i[k-1];
   end
   for (genvar k = 0; k < N_CLASS; k++) begin : g_win
      assign win[k] = hit_i[k] & ~blocked[k];
   end

   always_comb begin
      len_o = '0;
      for (int k = 0; k < N_CLASS; k++) begin
         if (win[k]) len_o = len_o | LEN_W'(k + 1);
      end
   end
endmodule

// File: rtl/vld_len_decoder.sv
module vld_len_decoder
   import vld_pkg::*;
#(
   parameter int OPC_BITS = OPC_W,
   parameter int LEN_BITS = LEN_W,
   parameter int N_CLASS  = CLASS_N,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [OPC_BITS-1:0] in_byte,
   output logic                len_valid,
   output logic [LEN_BITS-1:0] len_bytes
);
   localparam logic [LEN_BITS-1:0] LEN_RST = LEN_BITS'(1);

   if (OPC_BITS != 8) begin : g_bad_opc
      $error("vld_len_decoder: OPC_BITS must be 8");
   end

   logic [N_CLASS-1:0]  hit;
   logic [LEN_BITS-1:0] len_comb;

   vld_class_match #(.W(OPC_BITS), .N_CLASS(N_CLASS)) u_match (
      .byte_i(in_byte),
      .hit_o (hit)
   );

   vld_prio_len #(.N_CLASS(N_CLASS), .LEN_W(LEN_BITS)) u_prio (
      .hit_i(hit),
      .len_o(len_comb)
   );

   if (REG_OUT) begin : g_reg
      logic                vld_q;
      logic [LEN_BITS-1:0] len_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= 1'b0;
            len_q <= LEN_RST;
         end else begin
            vld_q <= in_valid;
            if (in_valid) len_q <= len_comb;
         end
      end
      assign len_valid = vld_q;
      assign len_bytes = len_q;
   end else begin : g_comb
      assign len_valid = in_valid;
      assign len_bytes = len_comb;
   end
endmodule

// File: rtl/vld_len_checker.sv
module vld_len_checker #(
   parameter int OPC_BITS = 8,
   parameter int LEN_BITS = 3,
   parameter bit REG_OUT  = 1'b1
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [OPC_BITS-1:0] in_byte,
   input logic                len_valid,
   input logic [LEN_BITS-1:0] len_bytes
);
   if (REG_OUT) begin : g_chk
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> len_valid);                                    // R2
      AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !len_valid);                                  // R2
      AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
         len_valid |-> (len_bytes != '0));                           // R3
      AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> $stable(len_bytes));                          // R11
      AST_SUBFIELD_DIFF: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_byte[7:6] == 2'b10 && in_byte[3:2] != in_byte[1:0])
         |=> (len_bytes == LEN_BITS'(1)));                           // R5
      AST_SUBFIELD_EQ: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_byte[7:6] == 2'b10 && in_byte[3:2] == in_byte[1:0])
         |=> (len_bytes == LEN_BITS'(2)));                           // R5
      AST_CB_SHORT: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_byte == 8'hCB) |=> (len_bytes == LEN_BITS'(1))); // R10
   end
endmodule

bind vld_len_decoder vld_len_checker #(
   .OPC_BITS(OPC_BITS), .LEN_BITS(LEN_BITS), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
   .len_valid(len_valid), .len_bytes(len_bytes)
);

// File: tb/vld_len_decoder_tb.sv
module vld_len_decoder_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic       in_valid;
   logic [7:0] in_byte;
   logic       len_valid;
   logic [2:0] len_bytes;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vld_len_decoder u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .len_valid(len_valid), .len_bytes(len_bytes)
   );

   // Reference written per upper nibble, independent of the mask tables.
   function automatic int ref_len(input logic [7:0] b);
      logic [3:0] hi = b[7:4];
      logic [3:0] lo = b[3:0];
      case (hi)
         4'h0: return (lo[1:0] == 2'b00) ? 1 : 3;
         4'h1, 4'h6, 4'h7, 4'hE: return 1;
         4'h2: return (lo[2] == 1'b0) ? 2 : 3;
         4'h3: return (lo >= 4'hC) ? 1 : 3;
         4'h4: return (lo[1] == 1'b0) ? 1 : 2;
         4'h5: return (lo < 4'h8) ? 1 : 2;
         4'h8, 4'h9, 4'hA, 4'hB: return (lo[3:2] == lo[1:0]) ? 2 : 1;
         4'hC: begin
            if (lo == 4'hB) return 1;
            if (lo == 4'hC) return 3;
            if (lo == 4'hD) return 5;
            return 2;
         end
         4'hD: begin
            if (lo < 4'hC) return 1;
            if (lo == 4'hC) return 5;
            if (lo == 4'hD) return 7;
            return 3;
         end
         default: begin
            if (lo <= 4'h6) return 2;
            if (lo == 4'h7 || lo == 4'hE) return 7;
            if (lo <= 4'h9) return 3;
            if (lo <= 4'hB) return 4;
            if (lo <= 4'hD) return 6;
            return 1;
         end
      endcase
   endfunction

   function automatic string req_of(input logic [7:0] b);
      int l = ref_len(b);
      if (b[7:6] == 2'b10) return "R5";
      if (b == 8'hCB || b == 8'hCC || b == 8'hCD) return "R10";
      case (l)
         1: return "R4";
         2: return "R6";
         3: return "R7";
         7: return "R9";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
      end
   endtask

   initial begin
      rst = 1'b1;
      in_valid = 1'b0;
      in_byte = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "len_valid after reset", int'(len_valid), 0);
      check("R1", "len_bytes after reset", int'(len_bytes), 1);
      rst = 1'b0;
      @(negedge clk);
      check("R2", "len_valid idle", int'(len_valid), 0);

      // Full sweep, one byte per cycle, result checked one cycle later.
      for (int v = 0; v < 256; v++) begin
         in_valid = 1'b1;
         in_byte = 8'(v);
         @(negedge clk);
         check("R2", "len_valid after strobe", int'(len_valid), 1);
         check(req_of(8'(v)), $sformatf("len of 0x%02h", v),
               int'(len_bytes), ref_len(8'(v)));
         if (len_bytes == 3'd0) check("R3", "zero length", 0, 1);
      end

      // R11: idle cycles with a moving byte must keep the held length.
      in_valid = 1'b1;
      in_byte = 8'hFC;
      @(negedge clk);
      check("R8", "len of 0xFC", int'(len_bytes), 6);
      for (int v = 0; v < 4; v++) begin
         in_valid = 1'b0;
         in_byte = 8'(8'h10 + v * 8'h33);
         @(negedge clk);
         check("R11", "len held while idle", int'(len_bytes), 6);
         check("R2", "len_valid low while idle", int'(len_valid), 0);
      end

      // Spot checks on priority and fall-through.
      begin
         logic [7:0] spots [6] = '{8'hCB, 8'hCC, 8'hCD, 8'hDD, 8'hAA, 8'hF7};
         int         exp_l [6] = '{1, 3, 5, 7, 2, 7};
         for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            in_byte = spots[i];
            @(negedge clk);
            check(i < 3 ? "R10" : (i == 4 ? "R5" : "R9"),
                  $sformatf("spot 0x%02h", spots[i]), int'(len_bytes), exp_l[i]);
         end
      end

      // Reset mid-stream.
      in_valid = 1'b1;
      in_byte = 8'hFA;
      rst = 1'b1;
      @(negedge clk);
      check("R1", "len_valid on reset", int'(len_valid), 0);
      check("R1", "len_bytes on reset", int'(len_bytes), 1);
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule